// File: doc/BRIEF.md
# Suspend-Aware Word Sender

This block sits on the transmit side of a link into a recording input. It takes words from an upstream valid/ready stream and puts each one on a word bus with a one-cycle strobe. The recorder controls the link through two lines, and both are asynchronous to the sender's clock. The first is a ready line, which opens a session when it goes high and closes it when it falls. The second is an active-low hold line. When the recorder pulls it low, the sender must stop strobing words within a fixed number of strobes.

Both recorder lines pass through a chain of flip-flops before the control logic sees them. The hold reaction therefore has a delay that the design must plan for. The synchronizer depth plus the one-cycle output register are subtracted from the permitted strobe limit. What remains is a grace budget. The sender may keep accepting words against that budget after it sees the synchronized hold, and then it stalls the upstream by dropping its ready. Words are never dropped or repeated across a pause or a session end. If the session closes while the upstream still offers a word, a one-cycle abort flag is raised.

The controller has four states:
- `ST_IDLE`: waits for the synchronized ready line. Its "session open" transition goes to `ST_SEND`.
- `ST_SEND`: accepts words. Its "budget spent" transition goes to `ST_PAUSE`, and its "session close" transition goes to `ST_STOP`.
- `ST_PAUSE`: holds the upstream. Its "resume" transition goes to `ST_SEND` once the hold is released, and its "session close" transition goes to `ST_STOP`.
- `ST_STOP`: lasts exactly one cycle. Its "drain done" transition goes to `ST_IDLE`.

Top module: `hold_aware_sender`

## Requirements
- R1: While `rst_n` is low, `out_stb`, `in_ready` and `abort_flag` are 0.
- R2: `in_ready` stays 0 and no word is strobed until `rdy_line` has been seen high through the `SYNC_STAGES`-flop synchronizer.
- R3: Each accepted word (`in_valid` and `in_ready` both 1 at a clock edge) appears on `out_word` with `out_stb` = 1 in the following cycle. Words appear in acceptance order, and none is lost or repeated.
- R4: `hold_n_async` is active low. A 0 requests a pause, and a 1 lets transfers continue. When the synchronized value returns to 1 in `ST_PAUSE`, the next state is `ST_SEND`.
- R5: From the cycle in which `hold_n_async` falls until it rises again, at most `HOLD_LIMIT` strobes occur. The cycle of the fall is included in this count.
- R6: Once the grace budget is used up, `in_ready` stays 0 and no strobe occurs while the hold lasts.
- R7: After `rdy_line` falls, at most `SYNC_STAGES` further strobes occur. After that, `in_ready` stays 0 until a new session opens.
- R8: `abort_flag` pulses for exactly one cycle on entry to `ST_STOP`, and only if `in_valid` was 1 when the session closed. Otherwise it stays 0.
- R9: After a session ends, a new rise of `rdy_line` opens a new session, and transfer continues with the next upstream word.
- R10: The grace budget restarts from zero each time the synchronized hold is released. A second hold with a continuously valid source therefore again allows exactly `HOLD_LIMIT` strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sender clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | DATA_W | Upstream word |
| in_valid | input | 1 | Upstream offers a word |
| in_ready | output | 1 | Sender takes the word at this edge |
| rdy_line | input | 1 | Recorder session line. High means open; a fall means end of session |
| hold_n_async | input | 1 | Recorder hold request, active low, asynchronous |
| out_word | output | DATA_W | Word bus to the recorder |
| out_stb | output | 1 | One-cycle strobe marking a word on `out_word` |
| abort_flag | output | 1 | One-cycle pulse when a session closes with a word still pending |

## Verification
The properties assume three things about the inputs. The upstream keeps `in_valid` and `in_data` steady until the word is taken. Each level of `rdy_line` and `hold_n_async` lasts at least one full clock period, so the synchronizer sees it. The strobe-window property counts from the raw hold line, so it relies on that line changing only between clock edges. The stimulus meets all three assumptions: it drives every input at the falling clock edge, holds each offered word until it is accepted, and toggles the recorder lines only at whole-cycle steps. It combines random valid rates and random hold toggling with directed holds and session ends under a continuously valid source.

// File: rtl/hsnd_pkg.sv
package hsnd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEND  = 2'd1,
        ST_PAUSE = 2'd2,
        ST_STOP  = 2'd3
    } hsnd_state_e;

    // words the sender may still take after it sees a synchronized hold
    function automatic int unsigned grace_words(input int unsigned limit,
                                                input int unsigned stages);
        int unsigned lag;
        lag = stages + 1;
        return (limit > lag) ? (limit - lag) : 0;
    endfunction

endpackage

// File: rtl/hsnd_sync.sv
module hsnd_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= RST_VAL;
                    else        chain[g] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= RST_VAL;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/hsnd_budget.sv
module hsnd_budget #(
    parameter int unsigned GRACE = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_act,
    input  logic take,
    output logic spent
);

    localparam int unsigned CNT_W = (GRACE < 1) ? 1 : $clog2(GRACE + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(GRACE);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!hold_act) begin
            cnt <= '0;
        end else if (take && !spent) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign spent = (cnt >= CNT_MAX);

endmodule

// File: rtl/hsnd_out_stage.sv
module hsnd_out_stage #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [DATA_W-1:0] word_in,
    input  logic              abort_set,
    output logic [DATA_W-1:0] word_q,
    output logic              stb_q,
    output logic              abort_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q  <= '0;
            stb_q   <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            stb_q   <= take;
            abort_q <= abort_set;
            if (take) word_q <= word_in;
        end
    end

endmodule

// File: rtl/hold_aware_sender.sv
module hold_aware_sender
    import hsnd_pkg::*;
#(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned HOLD_LIMIT  = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              rdy_line,
    input  logic              hold_n_async,
    output logic [DATA_W-1:0] out_word,
    output logic              out_stb,
    output logic              abort_flag
);

    localparam int unsigned GRACE = grace_words(HOLD_LIMIT, SYNC_STAGES);

    hsnd_state_e state, state_nxt;
    logic rdy_sync;
    logic hold_n_sync;
    logic hold_sync;
    logic budget_spent;
    logic take;
    logic abort_set;

    hsnd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rdy_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rdy_line),
        .q     (rdy_sync)
    );

    hsnd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_hold_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (hold_n_async),
        .q     (hold_n_sync)
    );

    assign hold_sync = ~hold_n_sync;
    assign take      = in_valid & in_ready;

    hsnd_budget #(.GRACE(GRACE)) u_budget (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_act (hold_sync),
        .take     (take),
        .spent    (budget_spent)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (rdy_sync) state_nxt = ST_SEND;              // session open
            ST_SEND: begin
                if (!rdy_sync)                      state_nxt = ST_STOP;  // session close
                else if (hold_sync && budget_spent) state_nxt = ST_PAUSE; // budget spent
            end
            ST_PAUSE: begin
                if (!rdy_sync)      state_nxt = ST_STOP;              // session close
                else if (!hold_sync) state_nxt = ST_SEND;             // resume
            end
            ST_STOP:  state_nxt = ST_IDLE;                            // drain done
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        abort_set = 1'b0;
        unique case (state)
            ST_IDLE:  in_ready = 1'b0;
            ST_SEND: begin
                in_ready  = rdy_sync & ~(hold_sync & budget_spent);
                abort_set = ~rdy_sync & in_valid;
            end
            ST_PAUSE: abort_set = ~rdy_sync & in_valid;
            ST_STOP:  in_ready = 1'b0;
            default:  in_ready = 1'b0;
        endcase
    end

    hsnd_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .word_in   (in_data),
        .abort_set (abort_set),
        .word_q    (out_word),
        .stb_q     (out_stb),
        .abort_q   (abort_flag)
    );

endmodule

// File: rtl/hold_aware_sender_chk.sv
module hold_aware_sender_chk
    import hsnd_pkg::*;
#(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned HOLD_LIMIT  = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] in_data,
    input logic              in_valid,
    input logic              in_ready,
    input logic              hold_n_async,
    input logic [DATA_W-1:0] out_word,
    input logic              out_stb,
    input logic              abort_flag,
    input logic              rdy_sync,
    input logic              hold_sync,
    input logic              budget_spent,
    input hsnd_state_e       state
);

    localparam int unsigned WIN_W = $clog2(HOLD_LIMIT + 2) + 1;
    localparam bit HAS_GRACE = (grace_words(HOLD_LIMIT, SYNC_STAGES) > 0);

    logic [WIN_W-1:0] win_cnt;

    // strobes seen since the raw hold line went low (saturating)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     win_cnt <= '0;
        else if (hold_n_async)          win_cnt <= '0;
        else if (out_stb && !(&win_cnt)) win_cnt <= win_cnt + 1'b1;
    end

    a_r1_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |-> (!out_stb && !abort_flag));

    a_r2_idle_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !in_ready);

    a_r3_strobe_follows_take: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_stb && out_word == $past(in_data)));

    a_r3_no_stray_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> !out_stb);

    a_r4_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAUSE && !hold_sync && rdy_sync) |=> (state == ST_SEND));

    a_r5_strobe_window: assert property (@(posedge clk) disable iff (!rst_n)
        win_cnt <= WIN_W'(HOLD_LIMIT));

    a_r6_pause_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAUSE) |-> !in_ready);

    a_r7_closed_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_sync |-> !in_ready);

    a_r8_abort_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
        abort_flag |-> (state == ST_STOP));

    a_r8_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
        abort_flag |=> !abort_flag);

    a_r10_budget_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_GRACE && !hold_sync) |=> !budget_spent);

endmodule

bind hold_aware_sender hold_aware_sender_chk #(
    .DATA_W      (DATA_W),
    .HOLD_LIMIT  (HOLD_LIMIT),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_data      (in_data),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .hold_n_async (hold_n_async),
    .out_word     (out_word),
    .out_stb      (out_stb),
    .abort_flag   (abort_flag),
    .rdy_sync     (rdy_sync),
    .hold_sync    (hold_sync),
    .budget_spent (budget_spent),
    .state        (state)
);

// File: tb/hold_aware_sender_tb.sv
module hold_aware_sender_tb;

    localparam int DW  = 16;
    localparam int LIM = 16;
    localparam int SYN = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic          rdy_line = 1'b0;
    logic          hold_n_async = 1'b1;
    logic [DW-1:0] out_word;
    logic          out_stb;
    logic          abort_flag;

    always #4 clk = ~clk;   // 125 MHz

    hold_aware_sender #(.DATA_W(DW), .HOLD_LIMIT(LIM), .SYNC_STAGES(SYN)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_data      (in_data),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .rdy_line     (rdy_line),
        .hold_n_async (hold_n_async),
        .out_word     (out_word),
        .out_stb      (out_stb),
        .abort_flag   (abort_flag)
    );

    int          total = 0;
    int          bad = 0;
    logic [DW-1:0] src_val = '0;
    logic [DW-1:0] exp_word = '0;
    bit          acc = 0;
    bit          last_stb = 0;
    int          strobes = 0;
    int          aborts = 0;
    int          ready_hits = 0;
    int          vprob = 0;
    int          win = 0;

    function automatic int exp_hold_burst();  return LIM; endfunction
    function automatic int exp_close_tail();  return SYN; endfunction
    function automatic logic [DW-1:0] next_word(input logic [DW-1:0] w); return w + 1'b1; endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic cycle();
        @(negedge clk);
        last_stb = out_stb;
        if (out_stb) begin
            chk(out_word == exp_word, "R3 word order", int'(out_word), int'(exp_word));
            exp_word = next_word(exp_word);
            strobes++;
            if (!hold_n_async) win++;
        end
        if (abort_flag) aborts++;
        if (acc) begin
            src_val  = next_word(src_val);
            in_valid = 1'b0;
        end
        if (!in_valid) in_valid = (int'($urandom_range(99)) < vprob);
        in_data = src_val;
        #1;
        acc = in_valid && in_ready;
        if (in_ready) ready_hits++;
    endtask

    task automatic set_hold(input logic v);
        hold_n_async = v;
        if (!v) win = last_stb ? 1 : 0;
    endtask

    task automatic directed_hold(input string req);
        int s0;
        int s1;
        vprob = 100;
        repeat (10) cycle();
        s0 = strobes - int'(last_stb);
        set_hold(1'b0);
        repeat (30) cycle();
        chk(strobes - s0 == exp_hold_burst(), req, strobes - s0, exp_hold_burst());
        s1 = strobes;
        ready_hits = 0;
        repeat (10) cycle();
        chk(strobes == s1, "R6 no strobe while paused", strobes - s1, 0);
        chk(ready_hits == 0, "R6 ready low while paused", ready_hits, 0);
        set_hold(1'b1);
        repeat (10) cycle();
        chk(strobes > s1, "R4 resume after release", strobes - s1, 1);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #(8 * 100000);
        chk(1'b0, "watchdog", 0, 1);
        summary();
        $finish;
    end

    initial begin
        int s0;
        int s_mid;
        void'($urandom(32'd2718));

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(out_stb == 1'b0, "R1 strobe in reset", int'(out_stb), 0);
        chk(in_ready == 1'b0, "R1 ready in reset", int'(in_ready), 0);
        chk(abort_flag == 1'b0, "R1 abort in reset", int'(abort_flag), 0);
        rst_n = 1'b1;

        // R2: nothing moves before the session line rises
        vprob = 60;
        ready_hits = 0;
        repeat (20) cycle();
        chk(ready_hits == 0, "R2 ready before session", ready_hits, 0);
        chk(strobes == 0, "R2 strobe before session", strobes, 0);

        // R3: random traffic within an open session
        rdy_line = 1'b1;
        repeat (300) cycle();
        chk(strobes > 0, "R3 traffic flows", strobes, 1);

        // R5/R6/R4: directed hold with a continuously valid source
        directed_hold("R5 burst after hold");
        // R10: budget restarts after release
        directed_hold("R10 second burst");

        // R5: random holds mixed with random valid rates
        repeat (2000) begin
            vprob = int'($urandom_range(100));
            cycle();
            if ($urandom_range(99) < 4) begin
                if (!hold_n_async) begin
                    chk(win <= LIM, "R5 random window", win, LIM);
                    set_hold(1'b1);
                end else begin
                    set_hold(1'b0);
                end
            end
        end
        if (!hold_n_async) begin
            chk(win <= LIM, "R5 random window", win, LIM);
            set_hold(1'b1);
        end
        repeat (10) cycle();

        // R7/R8: session close with a word pending
        vprob = 100;
        repeat (10) cycle();
        aborts = 0;
        s0 = strobes;
        rdy_line = 1'b0;
        repeat (SYN) cycle();
        s_mid = strobes;
        chk(s_mid - s0 <= exp_close_tail(), "R7 tail after close", s_mid - s0, exp_close_tail());
        ready_hits = 0;
        repeat (10) cycle();
        chk(strobes == s_mid, "R7 stopped after close", strobes - s_mid, 0);
        chk(ready_hits == 0, "R7 ready low after close", ready_hits, 0);
        chk(aborts == 1, "R8 abort with word pending", aborts, 1);

        // R9: new session, then close with an idle source
        rdy_line = 1'b1;
        repeat (30) cycle();
        chk(strobes > s_mid, "R9 restart transfers", strobes - s_mid, 1);
        vprob = 0;
        repeat (5) cycle();
        aborts = 0;
        rdy_line = 1'b0;
        repeat (10) cycle();
        chk(aborts == 0, "R8 no abort with idle source", aborts, 0);
        chk(exp_word == src_val, "R3 no word lost", int'(exp_word), int'(src_val));

        summary();
        $finish;
    end

endmodule